// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block produces the stimulus words for a built-in self-test of an 8-bit serial transceiver datapath. An internal binary counter walks through all 256 values. Each count is turned into its Gray-code word, and that word is XORed with a seed word. The result is the test pattern. Within one pass of the counter, neighbouring patterns differ in exactly one bit, which keeps switching activity in the circuit under test low.

Each full pass of the counter is an epoch. When an epoch ends, the seed moves forward one step of a maximal-length linear feedback shift register. After a set number of epochs, the generator raises `done` and stops until `start` is asserted again.

Patterns leave on a valid/ready stream. A pattern counts as taken on every clock edge where `pat_valid` and `pat_ready` are both high, so at most one pattern is taken per clock. Once `pat_valid` is high, it stays high and `pat_data` stays unchanged until the pattern is taken, whatever `start` does. The downstream side may hold `pat_ready` low for any number of cycles. `start` and `done` are plain level signals.

Top module: `lt_pattern_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pat_valid` and `done` are 0 and the counter is 0. The seed is taken from `seed_in`, or is 8'h01 when `seed_in` is zero, so `pat_data` shows that seed.
- R2: `pat_data` always equals `g ^ seed`, where `g = count ^ (count >> 1)` and `count` is the number of patterns taken so far in the current epoch.
- R3: Two patterns taken one after the other within the same epoch differ in exactly one bit.
- R4: The counter advances only on a clock edge with `pat_valid` and `pat_ready` both high. While `pat_valid` is high and `pat_ready` is low, `pat_valid` stays high and `pat_data` stays unchanged at the next edge.
- R5: A new pattern is offered (`pat_valid` rises, or stays high after a take) only if `start` was high at that edge. When `start` is low, generation pauses after any pending pattern is taken. Raising `start` again resumes from the same count.
- R6: Taking the pattern at count 255 returns the counter to 0 and steps the seed once: next = {s[6:0], s[7]^s[5]^s[4]^s[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. At all other times the seed holds.
- R7: `done` rises at the edge that takes the last pattern of epoch number EPOCHS (default 4, so after 1024 patterns taken). While `done` is high, `pat_valid` is 0 even if `start` stays high.
- R8: While `done` is high, a rising edge of `start` (low at one clock edge, high at the next) clears `done`. Generation then restarts at count 0 with the seed that has already been stepped.
- R9: The seed is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; loads the seed |
| start | input | 1 | Level enable for generation; a rising edge restarts the generator after `done` |
| seed_in | input | 8 | Seed value loaded at reset (zero is replaced by 8'h01) |
| pat_data | output | 8 | Current test pattern |
| pat_valid | output | 1 | Pattern offered on the stream |
| pat_ready | input | 1 | Downstream accepts the pattern |
| done | output | 1 | All programmed epochs have finished |

## Verification
The bench first drives a zero seed, then a non-zero seed, to tell the zero-seed substitution apart from a plain load. It runs a stretch with `pat_ready` held high; this isolates the Gray sequence and the one-bit distance between neighbouring patterns. It then holds `pat_ready` low in a repeating pattern and drops `start` with a pattern still pending; these show that back-pressure freezes the pattern and that a pause resumes from the same count. A full run through every epoch up to `done`, followed by a restart, exposes errors in seed stepping, in the epoch count and in the rising-edge handling of `start`.

// File: rtl/lt_bist_pkg.sv
package lt_bist_pkg;
  // Default pattern width, matching the transceiver byte path.
  localparam int unsigned DEF_PAT_W  = 8;
  // Feedback taps for x^8+x^6+x^5+x^4+1: register bits 7,5,4,3.
  localparam logic [7:0]  DEF_TAPS   = 8'b1011_1000;
  // Number of seed epochs before the generator reports completion.
  localparam int unsigned DEF_EPOCHS = 4;
endpackage

// File: rtl/lt_gray_counter.sv
module lt_gray_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] gray_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // Binary to reflected Gray, one bit per slice.
  assign gray_o[W-1] = cnt_q[W-1];
  for (genvar i = 0; i < W - 1; i++) begin : g_gray
    assign gray_o[i] = cnt_q[i] ^ cnt_q[i+1];
  end

  assign wrap_o = inc && (cnt_q == CNT_MAX);
endmodule

// File: rtl/lt_seed_lfsr.sv
module lt_seed_lfsr #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  TAPS = 8'b1011_1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed_in,
  input  logic         step,
  output logic [W-1:0] seed_o
);
  localparam logic [W-1:0] SAFE_SEED = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] seed_q;
  logic         fb;

  assign fb = ^(seed_q & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n)    seed_q <= (seed_in == '0) ? SAFE_SEED : seed_in;
    else if (step) seed_q <= {seed_q[W-2:0], fb};
  end

  assign seed_o = seed_q;
endmodule

// File: rtl/lt_epoch_ctrl.sv
module lt_epoch_ctrl #(
  parameter int unsigned EPOCHS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic epoch_end,
  input  logic start,
  output logic done_o,
  output logic done_next_o
);
  localparam int unsigned EP_W    = (EPOCHS > 1) ? $clog2(EPOCHS) : 1;
  localparam logic [EP_W-1:0] EP_LAST = EP_W'(EPOCHS - 1);

  logic [EP_W-1:0] ep_q, ep_d;
  logic            done_q, done_d;
  logic            start_q;

  always_comb begin
    ep_d   = ep_q;
    done_d = done_q;
    if (done_q && start && !start_q) begin
      done_d = 1'b0;
    end else if (epoch_end) begin
      if (ep_q == EP_LAST) begin
        ep_d   = '0;
        done_d = 1'b1;
      end else begin
        ep_d = ep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_q    <= '0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      ep_q    <= ep_d;
      done_q  <= done_d;
      start_q <= start;
    end
  end

  assign done_o      = done_q;
  assign done_next_o = done_d;
endmodule

// File: rtl/lt_pattern_gen.sv
module lt_pattern_gen
  import lt_bist_pkg::*;
#(
  parameter int unsigned        PAT_W  = DEF_PAT_W,
  parameter logic [PAT_W-1:0]   TAPS   = DEF_TAPS,
  parameter int unsigned        EPOCHS = DEF_EPOCHS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] seed_in,
  output logic [PAT_W-1:0] pat_data,
  output logic             pat_valid,
  input  logic             pat_ready,
  output logic             done
);
  logic             vld_q;
  logic             fire;
  logic             wrap;
  logic             done_next;
  logic [PAT_W-1:0] gray;
  logic [PAT_W-1:0] seed;

  assign fire = vld_q && pat_ready;

  lt_gray_counter #(.W(PAT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (fire),
    .gray_o (gray),
    .wrap_o (wrap)
  );

  lt_seed_lfsr #(.W(PAT_W), .TAPS(TAPS)) u_seed (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed_in (seed_in),
    .step    (wrap),
    .seed_o  (seed)
  );

  lt_epoch_ctrl #(.EPOCHS(EPOCHS)) u_epoch (
    .clk         (clk),
    .rst_n       (rst_n),
    .epoch_end   (wrap),
    .start       (start),
    .done_o      (done),
    .done_next_o (done_next)
  );

  // A pending beat is held until taken; new beats need start and no done.
  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= (vld_q && !pat_ready) || (start && !done_next);
  end

  assign pat_valid = vld_q;
  assign pat_data  = gray ^ seed;
endmodule

// File: rtl/lt_pattern_gen_chk.sv
module lt_pattern_gen_chk #(
  parameter int unsigned PAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [PAT_W-1:0] pat_data,
  input logic             pat_valid,
  input logic             pat_ready,
  input logic             done,
  input logic             fire,
  input logic             wrap,
  input logic [PAT_W-1:0] seed
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid && !pat_ready |=> pat_valid && $stable(pat_data));

  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !wrap |=> $countones(pat_data ^ $past(pat_data)) == 1);

  assert_seed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(seed));

  assert_idle_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pat_valid);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fire && wrap));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));

  assert_seed_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seed != '0);
endmodule

bind lt_pattern_gen lt_pattern_gen_chk #(.PAT_W(PAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pat_data  (pat_data),
  .pat_valid (pat_valid),
  .pat_ready (pat_ready),
  .done      (done),
  .fire      (fire),
  .wrap      (wrap),
  .seed      (seed)
);

// File: tb/tb_lt_pattern_gen.sv
module tb_lt_pattern_gen;
  localparam int CLK_PERIOD = 10;
  localparam int EPOCHS     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] seed_in = 8'h00;
  logic [7:0] pat_data;
  logic       pat_valid;
  logic       pat_ready = 1'b0;
  logic       done;

  int tests = 0;
  int fails = 0;

  // Behavioural reference state.
  int       m_cnt, m_ep;
  bit [7:0] m_seed;
  bit       m_vld, m_done, m_sq;
  bit [7:0] last_taken;
  bit       have_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  lt_pattern_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_in(seed_in),
    .pat_data(pat_data), .pat_valid(pat_valid), .pat_ready(pat_ready), .done(done)
  );

  function automatic bit [7:0] gray_of(int c);
    bit [7:0] b = 8'(c);
    return b ^ (b >> 1);
  endfunction

  function automatic bit [7:0] lfsr_next(bit [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset(bit [7:0] s);
    m_cnt = 0; m_ep = 0; m_vld = 0; m_done = 0; m_sq = 0; have_last = 0;
    m_seed = (s == 8'h00) ? 8'h01 : s;
  endtask

  // Negedge: compare, apply inputs, advance the model by one edge.
  task automatic cycle(bit st, bit rdy);
    bit fire, restart;
    @(negedge clk);
    check(pat_valid == m_vld, "R4 R5 R7 valid", int'(pat_valid), int'(m_vld));
    check(done == m_done, "R7 R8 done", int'(done), int'(m_done));
    check(pat_data == (gray_of(m_cnt) ^ m_seed), "R2 R6 data",
          int'(pat_data), int'(gray_of(m_cnt) ^ m_seed));
    start = st;
    pat_ready = rdy;
    fire = m_vld && rdy;
    restart = m_done && st && !m_sq;
    if (fire) begin
      if (have_last && m_cnt != 0)
        check($countones(pat_data ^ last_taken) == 1, "R3 distance",
              $countones(pat_data ^ last_taken), 1);
      last_taken = pat_data;
      have_last = 1;
    end
    if (restart) m_done = 0;
    else if (fire) begin
      if (m_cnt == 255) begin
        m_cnt = 0;
        m_seed = lfsr_next(m_seed);
        if (m_ep == EPOCHS - 1) begin m_ep = 0; m_done = 1; end
        else m_ep++;
      end else m_cnt++;
    end
    m_vld = (m_vld && !rdy) || (st && !m_done);
    m_sq = st;
  endtask

  task automatic do_reset(bit [7:0] s);
    @(negedge clk);
    rst_n = 1'b0; seed_in = s; start = 1'b0; pat_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset(s);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 R9: zero seed replaced by 8'h01.
    do_reset(8'h00);
    @(negedge clk);
    check(pat_valid == 1'b0, "R1 valid", int'(pat_valid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(pat_data == 8'h01, "R1 R9 zero seed", int'(pat_data), 8'h01);
    for (int i = 0; i < 3; i++) cycle(0, 1);

    // Free-running stream: R2, R3.
    for (int i = 0; i < 100; i++) cycle(1, 1);
    // Back-pressure: R4.
    for (int i = 0; i < 200; i++) cycle(1, (i % 3) != 0);
    // Pause with a beat pending, then resume: R5.
    cycle(0, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0);
    cycle(0, 1);
    for (int i = 0; i < 6; i++) cycle(0, 1);
    check(pat_valid == 1'b0, "R5 paused", int'(pat_valid), 0);
    for (int i = 0; i < 20; i++) cycle(1, 1);

    // Run through every epoch: R6, R7.
    for (int i = 0; i < 3000 && !m_done; i++) cycle(1, (i % 7) != 0);
    check(m_done == 1'b1, "R7 reached", int'(m_done), 1);
    for (int i = 0; i < 20; i++) cycle(1, 1);
    check(pat_valid == 1'b0, "R7 idle with start", int'(pat_valid), 0);

    // Restart on a rising start edge: R8 (seed now stepped four times).
    cycle(0, 1);
    cycle(1, 1);
    cycle(1, 1);
    check(done == 1'b0, "R8 cleared", int'(done), 0);
    check(pat_valid == 1'b1, "R8 resumed", int'(pat_valid), 1);
    for (int i = 0; i < 300; i++) cycle(1, 1);

    // Non-zero seed loaded as given: R1.
    do_reset(8'h5A);
    @(negedge clk);
    check(pat_data == 8'h5A, "R1 seed load", int'(pat_data), 8'h5A);
    for (int i = 0; i < 300; i++) cycle(1, (i % 5) != 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule